// File: doc/BRIEF.md
# Event-Gated Sample Capture Writer

This block sits between a pair of free-running 12-bit converters and a sample memory. On every storage strobe it merges the two samples and eight digital input lines into one 32-bit word. It then writes that word through a plain memory write port made of address, data and write enable. Storage is gated by three controls: a software run bit, a level-sensitive trigger input and an event input. Trigger and event are expected to default high when left unconnected.

When the event input goes low during acquisition, one more sample pair is stored. The next memory location then receives a timestamp word, and storage holds until event is high again. A timestamp word is also written when software run is removed during acquisition. The timestamp counter is 31 bits wide. It starts counting at the first data word of an acquisition and advances once every `TS_DIV` clocks, which is 100 ns with the default setting at 50 MHz. The buffer can be filled once, which then raises a stopped flag, or written as a circular buffer. A one-cycle request marks each time another eighth of the buffer has been filled.

Top module: `cw_capture_writer`

## Requirements
- R1: No word is written unless software run is 1 and trigger has been high with software run 1 for at least one clock edge; strobes given before that are dropped.
- R2: A data word holds channel 0 in bits 27..16, channel 1 in bits 11..0, digital inputs 7..4 in bits 31..28 and digital inputs 3..0 in bits 15..12.
- R3: The write for a strobe sampled at clock edge N appears on the write port during the cycle after edge N. Addresses start at 0 after an idle period and step by one for every word written.
- R4: A strobe that is sampled while event is low stores its sample pair. The following cycle writes a timestamp word to the next address. Strobes are then dropped until event is high again, and storage resumes at the next address.
- R5: A timestamp word has bit 31 = 1 and the counter in bits 30..0. The counter is cleared while idle, is 0 just after the edge that issues the first data write, and advances by one every `TS_DIV` clocks after that.
- R6: Clearing software run while acquiring writes one timestamp word at the next address. The next acquisition restarts at address 0 with the counter at 0.
- R7: With wrap clear, the write to the last address ends storage and raises stopped in the same cycle. Later strobes are dropped, and stopped returns to 0 once software run is cleared.
- R8: With wrap set, the address after the last location is 0, older words are overwritten and stopped stays 0.
- R9: The eighth-fill request is a one-cycle pulse that comes with the write to any address whose low `ADDR_W-3` bits are all ones. Timestamp words count as well, so one full pass produces eight pulses.
- R10: During and right after reset, write enable, eighth-fill request and stopped are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_run | input | 1 | Software run control |
| wrap_en | input | 1 | 1 selects circular buffer, 0 single fill |
| trig | input | 1 | Start trigger, level sensitive |
| evt | input | 1 | Storage gate; a low level pauses storage after a timestamp |
| smp_stb | input | 1 | Storage strobe, one cycle per sample pair |
| ch0_smp | input | 12 | Channel 0 sample |
| ch1_smp | input | 12 | Channel 1 sample |
| din | input | 8 | Digital input lines |
| mem_addr | output | ADDR_W | Write address |
| mem_wdata | output | 32 | Write data word |
| mem_we | output | 1 | Write enable |
| eighth_req | output | 1 | One-cycle pulse when an eighth of the buffer is completed |
| stopped | output | 1 | Single fill complete |

## Verification
The bench builds the block with `ADDR_W = 5` and `TS_DIV = 3`. A 32-word buffer with four-word eighths lets a full single fill, a wrapped pass with overwrite, and a timestamp that lands on an eighth boundary all run in a few hundred cycles. A divider of 3 makes the timestamp counter move several times between event changes. The bench can therefore compute each timestamp from the cycle distance to the first data write.

// File: rtl/cw_pkg.sv
package cw_pkg;
  localparam int SMP_W  = 12;
  localparam int DIN_W  = 8;
  localparam int WORD_W = 32;
  localparam int TS_W   = WORD_W - 1;
  localparam int NIB_W  = DIN_W / 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RUN,
    ST_TSW,
    ST_PAUSE,
    ST_DONE
  } cw_state_e;

  // Upper nibble of the digital lines rides above channel 0, lower nibble above channel 1.
  function automatic logic [WORD_W-1:0] pack_data(
    input logic [SMP_W-1:0] c0,
    input logic [SMP_W-1:0] c1,
    input logic [DIN_W-1:0] d
  );
    return {d[DIN_W-1:NIB_W], c0, d[NIB_W-1:0], c1};
  endfunction

  function automatic logic [WORD_W-1:0] pack_ts(input logic [TS_W-1:0] t);
    return {1'b1, t};
  endfunction
endpackage

// File: rtl/cw_ctrl.sv
module cw_ctrl
  import cw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sw_run,
  input  logic trig,
  input  logic evt,
  input  logic stb,
  input  logic last_slot,
  input  logic wrap_en,
  output logic do_data,
  output logic do_ts,
  output logic clr,
  output logic stopped
);
  cw_state_e state_q, state_d;
  logic fill_end;

  assign fill_end = last_slot && !wrap_en;

  always_comb begin
    state_d = state_q;
    do_data = 1'b0;
    do_ts   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (sw_run && trig) state_d = ST_RUN;
      end
      ST_RUN: begin
        if (!sw_run) begin
          do_ts   = 1'b1;
          state_d = ST_IDLE;
        end else if (stb) begin
          do_data = 1'b1;
          if (fill_end)  state_d = ST_DONE;
          else if (!evt) state_d = ST_TSW;
        end
      end
      ST_TSW: begin
        do_ts = 1'b1;
        if (!sw_run)       state_d = ST_IDLE;
        else if (fill_end) state_d = ST_DONE;
        else               state_d = ST_PAUSE;
      end
      ST_PAUSE: begin
        if (!sw_run)  state_d = ST_IDLE;
        else if (evt) state_d = ST_RUN;
      end
      ST_DONE: begin
        if (!sw_run) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign clr     = (state_q == ST_IDLE);
  assign stopped = (state_q == ST_DONE);
endmodule

// File: rtl/cw_addr_gen.sv
module cw_addr_gen #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adv,
  output logic [ADDR_W-1:0] ptr,
  output logic              last_slot,
  output logic              eighth_end
);
  localparam int SEG_W = ADDR_W - 3;

  logic [ADDR_W-1:0] ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr_q <= '0;
    else if (clr) ptr_q <= '0;
    else if (adv) ptr_q <= ptr_q + 1'b1;
  end

  assign ptr       = ptr_q;
  assign last_slot = &ptr_q;

  generate
    if (SEG_W > 0) begin : g_seg
      assign eighth_end = &ptr_q[SEG_W-1:0];
    end else begin : g_tiny
      assign eighth_end = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/cw_ts_counter.sv
module cw_ts_counter
  import cw_pkg::*;
#(
  parameter int TS_DIV = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            start,
  output logic [TS_W-1:0] ts
);
  localparam int PRE_W = (TS_DIV > 1) ? $clog2(TS_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TS_DIV - 1);

  logic             on_q;
  logic [PRE_W-1:0] pre_q;
  logic [TS_W-1:0]  cnt_q;
  logic             tick;

  assign tick = on_q && (pre_q == PRE_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q  <= 1'b0;
      pre_q <= '0;
      cnt_q <= '0;
    end else if (clr) begin
      on_q  <= 1'b0;
      pre_q <= '0;
      cnt_q <= '0;
    end else if (!on_q) begin
      if (start) on_q <= 1'b1;
    end else begin
      pre_q <= tick ? '0 : pre_q + 1'b1;
      if (tick) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ts = cnt_q;
endmodule

// File: rtl/cw_capture_writer.sv
module cw_capture_writer
  import cw_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int TS_DIV = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_run,
  input  logic              wrap_en,
  input  logic              trig,
  input  logic              evt,
  input  logic              smp_stb,
  input  logic [SMP_W-1:0]  ch0_smp,
  input  logic [SMP_W-1:0]  ch1_smp,
  input  logic [DIN_W-1:0]  din,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              eighth_req,
  output logic              stopped
);
  logic              do_data, do_ts, clr, wr_any;
  logic [ADDR_W-1:0] ptr;
  logic              last_slot, eighth_end;
  logic [TS_W-1:0]   ts_val;

  logic              we_q, eig_q, ts_wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] data_q;

  assign wr_any = do_data || do_ts;

  cw_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_run    (sw_run),
    .trig      (trig),
    .evt       (evt),
    .stb       (smp_stb),
    .last_slot (last_slot),
    .wrap_en   (wrap_en),
    .do_data   (do_data),
    .do_ts     (do_ts),
    .clr       (clr),
    .stopped   (stopped)
  );

  cw_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .adv        (wr_any),
    .ptr        (ptr),
    .last_slot  (last_slot),
    .eighth_end (eighth_end)
  );

  cw_ts_counter #(.TS_DIV(TS_DIV)) u_ts (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .start (do_data),
    .ts    (ts_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q    <= 1'b0;
      eig_q   <= 1'b0;
      ts_wr_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      we_q    <= wr_any;
      eig_q   <= wr_any && eighth_end;
      ts_wr_q <= do_ts;
      if (wr_any) begin
        addr_q <= ptr;
        data_q <= do_ts ? pack_ts(ts_val) : pack_data(ch0_smp, ch1_smp, din);
      end
    end
  end

  assign mem_we     = we_q;
  assign mem_addr   = addr_q;
  assign mem_wdata  = data_q;
  assign eighth_req = eig_q;
endmodule

// File: rtl/cw_checker.sv
module cw_checker #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sw_run,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_wdata,
  input logic              eighth_req,
  input logic              stopped,
  input logic              ts_wr
);
  a_r9_req_with_write: assert property (@(posedge clk) disable iff (!rst_n)
    eighth_req |-> mem_we);

  a_r7_stop_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stopped) |-> (mem_we && (&mem_addr)));

  a_r7_silent_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped && $past(stopped)) |-> !mem_we);

  a_r5_ts_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ts_wr |-> (mem_we && mem_wdata[31]));

  a_r4_gap_after_ts: assert property (@(posedge clk) disable iff (!rst_n)
    ts_wr |=> !mem_we);

  a_r6_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(sw_run) && !$past(sw_run, 2)) |-> !mem_we);
endmodule

bind cw_capture_writer cw_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sw_run     (sw_run),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .eighth_req (eighth_req),
  .stopped    (stopped),
  .ts_wr      (ts_wr_q)
);

// File: tb/sim_cw_capture_writer.sv
module sim_cw_capture_writer;
  localparam int AW  = 5;
  localparam int DIV = 3;

  logic clk = 0, rst_n = 0;
  logic sw_run = 0, wrap_en = 0, trig = 1, evt = 1, smp_stb = 0;
  logic [11:0] ch0_smp = 0, ch1_smp = 0;
  logic [7:0]  din = 0;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata;
  logic mem_we, eighth_req, stopped;

  int nchk = 0, nerr = 0, cyc = 0, nw = 0, neig = 0;
  logic [31:0] lg_d [0:255];
  int lg_a [0:255];
  int lg_c [0:255];
  logic lg_e [0:255];

  cw_capture_writer #(.ADDR_W(AW), .TS_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .sw_run(sw_run), .wrap_en(wrap_en), .trig(trig),
    .evt(evt), .smp_stb(smp_stb), .ch0_smp(ch0_smp), .ch1_smp(ch1_smp), .din(din),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .eighth_req(eighth_req), .stopped(stopped)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && mem_we && nw < 256) begin
      lg_d[nw] = mem_wdata;
      lg_a[nw] = int'(mem_addr);
      lg_c[nw] = cyc;
      lg_e[nw] = eighth_req;
      nw = nw + 1;
    end
    if (rst_n && eighth_req) neig = neig + 1;
  end

  function automatic logic [11:0] g0(input int s); return 12'((s * 37 + 5) & 12'hFFF); endfunction
  function automatic logic [11:0] g1(input int s); return 12'((~(s * 91)) & 12'hFFF); endfunction
  function automatic logic [7:0]  gd(input int s); return 8'((s * 29 + 3) & 8'hFF); endfunction

  function automatic logic [31:0] expd(input int s);
    int unsigned w;
    w = (int'(gd(s)) / 16) * (2 ** 28) + int'(g0(s)) * (2 ** 16)
      + (int'(gd(s)) % 16) * (2 ** 12) + int'(g1(s));
    return 32'(w);
  endfunction

  function automatic logic [31:0] expts(input int c_ts, input int c_first);
    return 32'h8000_0000 + 32'((c_ts - 1 - c_first) / DIV);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic strobe(input int s);
    @(posedge clk); #1;
    smp_stb = 1; ch0_smp = g0(s); ch1_smp = g1(s); din = gd(s);
    @(posedge clk); #1;
    smp_stb = 0;
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL R10 watchdog act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    int base, e0;
    // R10 reset state
    idle(3);
    @(negedge clk);
    chk("R10 we", 32'(mem_we), 0);
    chk("R10 eighth", 32'(eighth_req), 0);
    chk("R10 stopped", 32'(stopped), 0);
    rst_n = 1;
    idle(2);
    chk("R10 we after release", 32'(mem_we), 0);

    // R1 gating
    strobe(0); strobe(1);
    chk("R1 no run", 32'(nw), 0);
    sw_run = 1; trig = 0;
    strobe(2);
    chk("R1 no trigger", 32'(nw), 0);
    trig = 1;
    for (int s = 0; s < 4; s++) strobe(10 + s);
    chk("R1 started", 32'(nw), 4);
    for (int k = 0; k < 4; k++) begin
      chk("R2 data word", lg_d[k], expd(10 + k));
      chk("R3 address", 32'(lg_a[k]), 32'(k));
    end

    // R4 event pause, R5 timestamp
    evt = 0;
    strobe(14);
    strobe(15); strobe(16);
    chk("R4 count after event drop", 32'(nw), 6);
    chk("R4 last data", lg_d[4], expd(14));
    chk("R4 ts addr", 32'(lg_a[5]), 5);
    chk("R5 ts word", lg_d[5], expts(lg_c[5], lg_c[0]));
    evt = 1;
    strobe(17);
    chk("R4 resume data", lg_d[6], expd(17));
    chk("R4 resume addr", 32'(lg_a[6]), 6);

    // R6 run cleared
    sw_run = 0;
    idle(3);
    chk("R6 ts on stop count", 32'(nw), 8);
    chk("R6 ts addr", 32'(lg_a[7]), 7);
    chk("R6 ts word", lg_d[7], expts(lg_c[7], lg_c[0]));
    chk("R7 stopped low after run clear", 32'(stopped), 0);
    sw_run = 1;
    strobe(18);
    chk("R6 restart addr", 32'(lg_a[8]), 0);
    chk("R6 restart data", lg_d[8], expd(18));
    evt = 0;
    strobe(19);
    chk("R6 second addr", 32'(lg_a[9]), 1);
    chk("R6 ts restart addr", 32'(lg_a[10]), 2);
    chk("R6 counter restarted", lg_d[10], expts(lg_c[10], lg_c[8]));
    evt = 1; sw_run = 0;
    idle(3);

    // R7 single fill, R9 eighth requests
    base = nw; e0 = neig;
    sw_run = 1;
    for (int s = 0; s < 32; s++) strobe(100 + s);
    chk("R7 full count", 32'(nw - base), 32);
    chk("R7 stopped", 32'(stopped), 1);
    for (int s = 0; s < 32; s++) begin
      chk("R3 fill addr", 32'(lg_a[base + s]), 32'(s));
      chk("R9 pulse place", 32'(lg_e[base + s]), 32'((s % 4) == 3));
    end
    chk("R9 eight pulses", 32'(neig - e0), 8);
    strobe(200); strobe(201);
    chk("R7 dropped after full", 32'(nw - base), 32);
    sw_run = 0;
    idle(2);
    chk("R7 stopped cleared", 32'(stopped), 0);
    chk("R7 no ts from done", 32'(nw - base), 32);

    // R8 wrap
    wrap_en = 1;
    base = nw; e0 = neig;
    sw_run = 1;
    for (int s = 0; s < 42; s++) strobe(300 + s);
    chk("R8 count", 32'(nw - base), 42);
    chk("R8 wrapped addr", 32'(lg_a[base + 32]), 0);
    chk("R8 overwrite data", lg_d[base + 32], expd(332));
    chk("R8 later addr", 32'(lg_a[base + 41]), 9);
    chk("R8 not stopped", 32'(stopped), 0);
    evt = 0;
    strobe(400);
    chk("R4 wrap data addr", 32'(lg_a[base + 42]), 10);
    chk("R9 ts addr", 32'(lg_a[base + 43]), 11);
    chk("R9 ts on boundary", 32'(lg_e[base + 43]), 1);
    chk("R5 wrap ts", lg_d[base + 43], expts(lg_c[base + 43], lg_c[base]));
    chk("R9 pulse count wrap", 32'(neig - e0), 11);
    evt = 1; sw_run = 0; wrap_en = 0;
    idle(3);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule